// File: doc/BRIEF.md
# MAC Error Status Collector

This block gathers the error pulses raised around a network MAC's receive and transmit paths and holds them in one error status word. The queues that carry frame lengths and transmit results report overflow and underflow. The receive data buffer reports overflow. The receive frame checker reports seven kinds of bad frame. Every pulse lasts one clock cycle and latches its own status bit. Four of the frame errors also advance saturating counters. Software can read the counters and the status word through a small register read port.

Status bits fall into two classes. Faults on the length and result queues leave the MAC in a state that only a device reset repairs. Their bits are sticky: software writes cannot clear them, and a reset-needed flag stays high while any of them is set. The data buffer overflow bit and the frame error bits are cleared by software with a write-one-to-clear mask. A summary bit tells whether any frame error bit is set. The read port and the clear port are plain register strobes, with no back-pressure. A read issued in one cycle returns its data in the next.

Top module: `mac_err_status`

## Requirements
- R1: After reset the status word, all four counters, the reset-needed flag and the read-valid flag are all zero.
- R2: A strobe on evt_i bit n sets status bit n on the next clock edge. The bits are: 0 receive length queue overflow, 1 receive length queue underflow, 2 transmit result queue overflow, 3 transmit result queue underflow, 4 transmit length queue overflow, 5 transmit length queue underflow, 6 receive data buffer overflow, 7 missed frame, 8 receive collision, 9 FCS error, 10 bad length field, 11 frame too short, 12 frame too long, 13 non-byte-aligned frame. Strobes on several bits in one cycle each set their own bit.
- R3: Status bits 0 to 5 are sticky. A clear write leaves them unchanged, and only reset clears them.
- R4: When clr_we_i is high, every bit from 6 to 13 whose clr_mask_i bit is 1 clears on the next edge. Bits whose mask bit is 0 keep their value.
- R5: If a strobe and a clear reach the same bit in the same cycle, the bit ends up set.
- R6: Status bit 14 is the frame error summary. It is 1 exactly when at least one of bits 7 to 13 is set, and it follows those bits with no extra delay.
- R7: reset_needed_o is 1 exactly when at least one of status bits 0 to 5 is set.
- R8: Four counters advance by one for each strobe on their source bit: missed frames (bit 7), collisions (bit 8), FCS errors (bit 9) and alignment errors (bit 13). Strobes on several sources in one cycle advance each matching counter. Clear writes do not change the counters.
- R9: A counter that reaches 2^CNT_W-1 stays at that value.
- R10: A read with rd_en_i high returns data on the next cycle, with rd_valid_o high. The addresses are: 0 the status word, 1 the missed-frame counter, 2 the collision counter, 3 the FCS counter, 4 the alignment counter. Any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous device reset |
| evt_i | input | 14 | Single-cycle error strobes, one per status bit 0..13 |
| clr_we_i | input | 1 | Clear write strobe |
| clr_mask_i | input | 14 | Write-one-to-clear mask for status bits 0..13 |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data, valid one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| status_o | output | 15 | Error status word, with bit 14 as the frame error summary |
| cnt_o | output | 4*CNT_W | Counters packed missed, collision, FCS, alignment from the low end |
| reset_needed_o | output | 1 | A sticky queue fault is latched |

## Verification
The bench drives the block with several input patterns, and each pattern separates two outcomes:
- A lone strobe on one bit shows whether the bit mapping is right, and whether the reset-needed flag follows only the sticky class.
- A burst on three frame error bits in one cycle separates per-bit latching and per-counter counting from an encoder that keeps only one event.
- A clear mask of all ones over every set bit separates sticky bits from clearable ones.
- A partial mask shows whether only the selected bits clear.
- A strobe that meets a clear on the same bit separates set-wins from clear-wins.
- A long run of strobes on one counter shows whether the counter saturates or wraps.
- Reads at mapped and unmapped addresses check the one-cycle read latency and the address decoding.

// File: rtl/mac_err_pkg.sv
`timescale 1ns/1ps
package mac_err_pkg;
  localparam int EVT_W   = 14;
  localparam int STAT_W  = EVT_W + 1;
  localparam int SUM_BIT = EVT_W;
  localparam int CNT_N   = 4;
  localparam int RADDR_W = 3;

  localparam logic [EVT_W-1:0] STICKY_MASK = 14'h003F;
  localparam logic [EVT_W-1:0] W1C_MASK    = ~STICKY_MASK;
  localparam logic [EVT_W-1:0] FRAME_MASK  = 14'h3F80;

  typedef enum logic [RADDR_W-1:0] {
    RA_STATUS = 3'd0,
    RA_MISSED = 3'd1,
    RA_COLL   = 3'd2,
    RA_FCS    = 3'd3,
    RA_ALIGN  = 3'd4
  } rd_addr_e;

  function automatic int cnt_src(input int idx);
    case (idx)
      0:       cnt_src = 7;
      1:       cnt_src = 8;
      2:       cnt_src = 9;
      default: cnt_src = 13;
    endcase
  endfunction
endpackage

// File: rtl/mac_err_sat_cnt.sv
`timescale 1ns/1ps
module mac_err_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && cnt_q != MAX) |=> (cnt_q == W'($past(cnt_q) + 1'b1)))
    else $error("counter did not step");

  assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q))
    else $error("counter moved without a strobe");

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX) |=> (cnt_q == MAX))
    else $error("counter wrapped");
endmodule

// File: rtl/mac_err_status_reg.sv
`timescale 1ns/1ps
module mac_err_status_reg
  import mac_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              clr_we_i,
  input  logic [EVT_W-1:0]  clr_mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              reset_needed_o
);
  logic [EVT_W-1:0] bits_q, bits_d, clr_eff;
  logic             sum_q, fault_q;

  always_comb begin
    clr_eff = clr_we_i ? (clr_mask_i & W1C_MASK) : '0;
    bits_d  = (bits_q & ~clr_eff) | evt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q  <= '0;
      sum_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      bits_q  <= bits_d;
      sum_q   <= |(bits_d & FRAME_MASK);
      fault_q <= fault_q | (|(evt_i & STICKY_MASK));
    end
  end

  assign status_o       = {sum_q, bits_q};
  assign reset_needed_o = fault_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((bits_q & $past(evt_i)) == $past(evt_i)))
    else $error("strobe lost");

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bits_q & STICKY_MASK) != '0) |=>
      ((bits_q & $past(bits_q) & STICKY_MASK) == ($past(bits_q) & STICKY_MASK)))
    else $error("sticky bit cleared");

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((bits_q & $past(clr_mask_i & ~evt_i) & W1C_MASK) == '0))
    else $error("clearable bit stayed set");

  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q == (|(bits_q & FRAME_MASK)))
    else $error("summary mismatch");

  assert_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q == (|(bits_q & STICKY_MASK)))
    else $error("reset-needed mismatch");
endmodule

// File: rtl/mac_err_rdport.sv
`timescale 1ns/1ps
module mac_err_rdport
  import mac_err_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en_i,
  input  logic [RADDR_W-1:0]     rd_addr_i,
  input  logic [STAT_W-1:0]      status_i,
  input  logic [CNT_N*CNT_W-1:0] cnt_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_valid_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (rd_addr_i)
      RA_STATUS: sel = DATA_W'(status_i);
      RA_MISSED: sel = DATA_W'(cnt_i[0*CNT_W +: CNT_W]);
      RA_COLL:   sel = DATA_W'(cnt_i[1*CNT_W +: CNT_W]);
      RA_FCS:    sel = DATA_W'(cnt_i[2*CNT_W +: CNT_W]);
      RA_ALIGN:  sel = DATA_W'(cnt_i[3*CNT_W +: CNT_W]);
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= sel;
    end
  end

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o)
    else $error("read not answered");

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o)
    else $error("spurious read valid");
endmodule

// File: rtl/mac_err_status.sv
`timescale 1ns/1ps
module mac_err_status
  import mac_err_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EVT_W-1:0]       evt_i,
  input  logic                   clr_we_i,
  input  logic [EVT_W-1:0]       clr_mask_i,
  input  logic                   rd_en_i,
  input  logic [RADDR_W-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_valid_o,
  output logic [STAT_W-1:0]      status_o,
  output logic [CNT_N*CNT_W-1:0] cnt_o,
  output logic                   reset_needed_o
);
  mac_err_status_reg u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt_i),
    .clr_we_i       (clr_we_i),
    .clr_mask_i     (clr_mask_i),
    .status_o       (status_o),
    .reset_needed_o (reset_needed_o)
  );

  for (genvar g = 0; g < CNT_N; g++) begin : g_cnt
    mac_err_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (evt_i[cnt_src(g)]),
      .count_o (cnt_o[g*CNT_W +: CNT_W])
    );
  end

  mac_err_rdport #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .status_i   (status_o),
    .cnt_i      (cnt_o),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: tb/mac_err_status_bench.sv
`timescale 1ns/1ps
module mac_err_status_bench;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt = '0;
  logic        clr_we = 1'b0;
  logic [13:0] clr_mask = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [14:0] status;
  logic [4*CW-1:0] cnt;
  logic        reset_needed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_err_status #(.CNT_W(CW), .DATA_W(32)) u_mac_err_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .status_o(status),
    .cnt_o(cnt), .reset_needed_o(reset_needed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cval(input int i);
    return 32'(cnt[i*CW +: CW]);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; evt = '0; clr_we = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse(input logic [13:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic wr_clear(input logic [13:0] m);
    @(negedge clk); clr_we = 1'b1; clr_mask = m;
    @(negedge clk); clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data; v = rd_valid;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 counters", cnt, '0);
    chk("R1 reset_needed", 32'(reset_needed), 32'h0);
    chk("R1 rd_valid", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_single();
    do_reset();
    pulse(14'h0040);
    chk("R2 data overflow bit", 32'(status), 32'h0040);
    chk("R7 no fault on clearable bit", 32'(reset_needed), 32'h0);
    pulse(14'h0001);
    chk("R2 length queue bit", 32'(status), 32'h0041);
    chk("R7 fault flag", 32'(reset_needed), 32'h1);
  endtask

  task automatic t_multi();
    do_reset();
    pulse(14'h2300);
    chk("R2 R6 three bits plus summary", 32'(status), 32'h6300);
    chk("R8 collision", cval(1), 32'd1);
    chk("R8 fcs", cval(2), 32'd1);
    chk("R8 align", cval(3), 32'd1);
    chk("R8 missed idle", cval(0), 32'd0);
  endtask

  task automatic t_sticky();
    do_reset();
    pulse(14'h003F);
    wr_clear(14'h3FFF);
    chk("R3 sticky survive clear", 32'(status), 32'h003F);
    chk("R7 fault held", 32'(reset_needed), 32'h1);
  endtask

  task automatic t_w1c();
    do_reset();
    pulse(14'h3FC0);
    wr_clear(14'h0180);
    chk("R4 partial clear", 32'(status), 32'h7E40);
    chk("R8 counters unchanged by clear", cval(0), 32'd1);
    wr_clear(14'h3E40);
    chk("R4 R6 all cleared, summary low", 32'(status), 32'h0);
  endtask

  task automatic t_set_wins();
    do_reset();
    pulse(14'h0200);
    @(negedge clk); evt = 14'h0200; clr_we = 1'b1; clr_mask = 14'h0200;
    @(negedge clk); evt = '0; clr_we = 1'b0; clr_mask = '0;
    chk("R5 set wins", 32'(status), 32'h4200);
    chk("R8 fcs twice", cval(2), 32'd2);
  endtask

  task automatic t_read();
    logic [31:0] d; logic v;
    do_reset();
    pulse(14'h0080); pulse(14'h0080); pulse(14'h0080);
    rd(3'd1, d, v);
    chk("R10 valid", 32'(v), 32'h1);
    chk("R10 R8 missed count", d, 32'd3);
    rd(3'd0, d, v);
    chk("R10 status read", d, 32'h4080);
    rd(3'd5, d, v);
    chk("R10 unmapped zero", d, 32'h0);
  endtask

  task automatic t_sat();
    do_reset();
    @(negedge clk); evt = 14'h2000;
    for (int i = 0; i < 300; i++) @(negedge clk);
    evt = '0;
    chk("R9 saturated", cval(3), 32'd255);
    pulse(14'h2000);
    chk("R9 held at max", cval(3), 32'd255);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_sticky();
    t_w1c();
    t_set_wins();
    t_read();
    t_sat();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule